// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides which of two DMA channels owns a shared bus interface. Each channel presents a transfer request, a priority bit, a synchronization mode bit and two stop conditions (terminate and suspend). The arbiter issues a one-hot grant and then steps the owning channel through one transfer. A transfer is a fetch bus cycle followed by a deposit bus cycle, and each bus cycle ends when the bus side pulses `bus_done`.

When the two priority bits differ, the high channel wins. When they are equal, the channels take turns, and the channel that last completed a transfer yields. A channel in destination-synchronized mode leaves the bus idle for a fixed window after every deposit. During that window the bus is released, so the other channel can slip in one transfer before the first channel regains the bus. A source-synchronized channel chains its transfers back to back with no gap.

Top module: `dma_pair_arbiter`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `grant` is 00, `bus_cyc` is 0, `cyc_deposit` is 0 and `rest_active` is 0.
- R2: A channel is eligible when its `ch_req` bit is 1 and its `ch_term` and `ch_susp` bits are 0. A new grant goes only to a channel that was eligible at the deciding clock edge. With no eligible channel, `grant` stays 00.
- R3: If both channels are eligible at a deciding edge outside the release window and their `ch_prio_hi` bits differ (1 = high), the channel whose bit is 1 is granted.
- R4: If both channels are eligible outside the release window and their `ch_prio_hi` bits are equal, the channel that did not complete the most recent transfer is granted. After reset, channel 0 is treated as preferred.
- R5: A granted transfer holds `grant` stable. It shows a fetch phase (`bus_cyc`=1, `cyc_deposit`=0) until a cycle with `bus_done`=1, then a deposit phase (`cyc_deposit`=1) until the next `bus_done`.
- R6: When a deposit completes for a channel whose `ch_dst_sync` bit is 1, `rest_active` is 1 and `grant` is 00 for exactly REST_CYCLES (default 2) cycles.
- R7: At the end of the release window, the other channel is granted if it is eligible, whatever its priority. Otherwise the resting channel is granted again if it is eligible.
- R8: After a low-priority channel finishes a transfer that it took during a release window, the high-priority channel is granted next if it is still eligible. With both requests held, the two channels alternate.
- R9: When a deposit completes for a channel whose `ch_dst_sync` bit is 0 and some channel is eligible, a new fetch phase starts in the very next cycle with no idle cycle.
- R10: Raising `ch_term` or `ch_susp` or dropping `ch_req` during a transfer does not cut that transfer short. Those inputs act only at deciding edges.
- R11: `grant` is always one-hot or zero, and `bus_cyc` is 1 exactly when `grant` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_req | input | 2 | Transfer request, one bit per channel |
| ch_prio_hi | input | 2 | Priority bit per channel, 1 = high |
| ch_dst_sync | input | 2 | 1 = destination-synchronized (idle window after deposit), 0 = source-synchronized |
| ch_term | input | 2 | Channel terminated, blocks new grants |
| ch_susp | input | 2 | Channel suspended, blocks new grants |
| bus_done | input | 1 | Current bus cycle completes this clock |
| grant | output | 2 | One-hot bus ownership |
| bus_cyc | output | 1 | A fetch or deposit bus cycle is in progress |
| cyc_deposit | output | 1 | Current bus cycle is the deposit phase |
| rest_active | output | 1 | Post-deposit idle window, bus released |

## Verification
The bound checker watches, on every cycle, that the grant is one-hot and matches `bus_cyc`, that the fetch and deposit phases hold the grant, and that the release window follows only a destination-synchronized deposit and lasts exactly REST_CYCLES. On each fresh fetch it also checks the fixed-priority winner, the rotation rule and the hand-over at the end of the window. Some behaviour needs a specific history that only the bench's scenarios set up: channel 0 being preferred straight after reset, the complete alternation of a high destination-synchronized channel with a low source-synchronized one, and stop inputs that arrive in the middle of a transfer without aborting it. A random run then compares every output against a cycle model in the bench.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the two-channel DMA arbiter.
// Assumes exactly two channels; a channel index is a single bit.
package dma_arb_pkg;
    localparam int NCH   = 2;
    localparam int IDX_W = 1;

    typedef logic [IDX_W-1:0] ch_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_DEPOSIT = 2'd2,
        ST_REST    = 2'd3
    } arb_state_t;
endpackage

// File: rtl/dma_arb_qualify.sv
`timescale 1ns/1ps
// Per-channel eligibility: a channel may win arbitration only while it
// requests and is neither terminated nor suspended.
// Assumes all inputs are synchronous to the arbiter clock.
module dma_arb_qualify
    import dma_arb_pkg::*;
(
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] term,
    input  logic [NCH-1:0] susp,
    output logic [NCH-1:0] elig
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Combine request with both stop conditions for channel i.
        assign elig[i] = req[i] & ~term[i] & ~susp[i];
    end
endmodule

// File: rtl/dma_arb_pick.sv
`timescale 1ns/1ps
// Combinational winner selection between two eligible channels.
// Order of rules: a single eligible channel wins outright; a demoted
// channel (just left its idle window) yields to the other; differing
// priority bits select the high one; equal bits select the channel
// that did not complete the last transfer.
module dma_arb_pick
    import dma_arb_pkg::*;
(
    input  logic [NCH-1:0] elig,
    input  logic [NCH-1:0] prio_hi,
    input  ch_idx_t        last_idx,
    input  logic           demote_en,
    input  ch_idx_t        demote_idx,
    output logic           any,
    output ch_idx_t        win
);
    // Apply the selection rules in order of precedence.
    always_comb begin
        any = |elig;
        win = '0;
        if (elig == 2'b00) begin
            win = '0;
        end else if (elig != 2'b11) begin
            win = elig[1];
        end else if (demote_en) begin
            win = ~demote_idx;
        end else if (prio_hi[0] != prio_hi[1]) begin
            win = prio_hi[1];
        end else begin
            win = ~last_idx;
        end
    end
endmodule

// File: rtl/dma_arb_rest_timer.sv
`timescale 1ns/1ps
// Counts the post-deposit idle window of a destination-synchronized
// channel. A start pulse opens the window; expire is high in its last
// cycle. Assumes REST_CYCLES >= 1 and no start while already active.
module dma_arb_rest_timer #(
    parameter int REST_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic expire
);
    localparam int CNT_W = $clog2(REST_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(REST_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;

    assign active = active_q;
    assign expire = active_q && (cnt_q == LAST_CNT);

    // Open the window on start, advance the count, close it on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (expire) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dma_pair_arbiter.sv
`timescale 1ns/1ps
// Two-channel DMA bus arbiter. Grants the shared bus to one channel,
// sequences its fetch and deposit bus cycles through bus_done, and
// decides the next owner only at transfer boundaries. After a
// destination-synchronized deposit the bus is released for
// REST_CYCLES idle cycles, after which the other channel is preferred.
// Assumes bus_done is meaningful only while bus_cyc is high.
module dma_pair_arbiter
    import dma_arb_pkg::*;
#(
    parameter int REST_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ch_req,
    input  logic [1:0] ch_prio_hi,
    input  logic [1:0] ch_dst_sync,
    input  logic [1:0] ch_term,
    input  logic [1:0] ch_susp,
    input  logic       bus_done,
    output logic [1:0] grant,
    output logic       bus_cyc,
    output logic       cyc_deposit,
    output logic       rest_active
);
    arb_state_t     state_q, state_d;
    ch_idx_t        owner_q, owner_d;
    ch_idx_t        last_q,  last_d;
    logic [NCH-1:0] elig;
    logic           pick_any;
    ch_idx_t        pick_win;
    ch_idx_t        pick_last;
    logic           dep_end;
    logic           rest_start;
    logic           rest_on;
    logic           rest_expire;

    dma_arb_qualify u_qual (
        .req  (ch_req),
        .term (ch_term),
        .susp (ch_susp),
        .elig (elig)
    );

    // The channel finishing a deposit counts as the latest completer.
    assign pick_last = (state_q == ST_DEPOSIT) ? owner_q : last_q;

    dma_arb_pick u_pick (
        .elig       (elig),
        .prio_hi    (ch_prio_hi),
        .last_idx   (pick_last),
        .demote_en  (state_q == ST_REST),
        .demote_idx (owner_q),
        .any        (pick_any),
        .win        (pick_win)
    );

    assign dep_end    = (state_q == ST_DEPOSIT) && bus_done;
    assign rest_start = dep_end && ch_dst_sync[owner_q];

    dma_arb_rest_timer #(.REST_CYCLES(REST_CYCLES)) u_rest (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rest_start),
        .active (rest_on),
        .expire (rest_expire)
    );

    // Next-state logic for transfer sequencing and ownership hand-over.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        last_d  = last_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_any) begin
                    state_d = ST_FETCH;
                    owner_d = pick_win;
                end
            end
            ST_FETCH: begin
                if (bus_done) state_d = ST_DEPOSIT;
            end
            ST_DEPOSIT: begin
                if (bus_done) begin
                    last_d = owner_q;
                    if (ch_dst_sync[owner_q]) begin
                        state_d = ST_REST;
                    end else if (pick_any) begin
                        state_d = ST_FETCH;
                        owner_d = pick_win;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_REST: begin
                if (rest_expire) begin
                    if (pick_any) begin
                        state_d = ST_FETCH;
                        owner_d = pick_win;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State registers; channel 0 is preferred first after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            last_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            last_q  <= last_d;
        end
    end

    assign bus_cyc     = (state_q == ST_FETCH) || (state_q == ST_DEPOSIT);
    assign cyc_deposit = (state_q == ST_DEPOSIT);
    assign rest_active = (state_q == ST_REST) && rest_on;

    for (genvar i = 0; i < NCH; i++) begin : g_grant
        // Decode the owner index into its one-hot grant bit.
        assign grant[i] = bus_cyc && (owner_q == IDX_W'(i));
    end
endmodule

// File: rtl/dma_pair_arbiter_chk.sv
`timescale 1ns/1ps
// Property checker for dma_pair_arbiter, attached by bind. Observes
// ports only and keeps small history registers of its own.
module dma_pair_arbiter_chk #(
    parameter int REST_CYCLES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ch_req,
    input logic [1:0] ch_prio_hi,
    input logic [1:0] ch_dst_sync,
    input logic [1:0] ch_term,
    input logic [1:0] ch_susp,
    input logic       bus_done,
    input logic [1:0] grant,
    input logic       bus_cyc,
    input logic       cyc_deposit,
    input logic       rest_active
);
    logic [1:0]  elig;
    logic        fetching;
    logic [1:0]  held_q;
    logic [1:0]  done_ch_q;
    int unsigned run_q;

    assign elig     = ch_req & ~ch_term & ~ch_susp;
    assign fetching = bus_cyc && !cyc_deposit;

    // Track last owner, last completer and the length of the idle run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q    <= 2'b00;
            done_ch_q <= 2'b10;
            run_q     <= 0;
        end else begin
            if (grant != 2'b00) held_q <= grant;
            if (cyc_deposit && bus_done) done_ch_q <= grant;
            run_q <= rest_active ? run_q + 1 : 0;
        end
    end

    a_r11_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r11_bus_matches_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 2'b00) == bus_cyc);
    a_r2_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && !$past(fetching)) |-> (($past(elig) & grant) != 2'b00));
    a_r3_fixed_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && !$past(fetching) && !$past(rest_active) && $past(elig) == 2'b11
         && $past(ch_prio_hi[0] != ch_prio_hi[1])) |-> (grant == $past(ch_prio_hi)));
    a_r4_rotate_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && !$past(fetching) && !$past(rest_active) && $past(elig) == 2'b11
         && $past(ch_prio_hi[0] == ch_prio_hi[1])) |-> (grant != done_ch_q));
    a_r5_fetch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && !bus_done) |=> (fetching && $stable(grant)));
    a_r5_fetch_to_deposit: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && bus_done) |=> (cyc_deposit && $stable(grant)));
    a_r5_deposit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_deposit && !bus_done) |=> (cyc_deposit && $stable(grant)));
    a_r6_rest_after_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_deposit && bus_done && ((grant & ch_dst_sync) != 2'b00)) |=> rest_active);
    a_r6_rest_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rest_active) |-> $past(cyc_deposit && bus_done && ((grant & ch_dst_sync) != 2'b00)));
    a_r6_rest_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        rest_active |-> (grant == 2'b00));
    a_r6_rest_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rest_active |-> (run_q < REST_CYCLES));
    a_r6_rest_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rest_active) |-> (run_q == REST_CYCLES));
    a_r7_other_after_rest: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rest_active) && !rest_active && ($past(elig) & ~held_q) != 2'b00)
        |-> (grant == ($past(elig) & ~held_q)));
    a_r9_no_gap_src: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_deposit && bus_done && ((grant & ch_dst_sync) == 2'b00) && elig != 2'b00)
        |=> fetching);
endmodule

bind dma_pair_arbiter dma_pair_arbiter_chk #(.REST_CYCLES(REST_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_req      (ch_req),
    .ch_prio_hi  (ch_prio_hi),
    .ch_dst_sync (ch_dst_sync),
    .ch_term     (ch_term),
    .ch_susp     (ch_susp),
    .bus_done    (bus_done),
    .grant       (grant),
    .bus_cyc     (bus_cyc),
    .cyc_deposit (cyc_deposit),
    .rest_active (rest_active)
);

// File: tb/sim_dma_pair_arbiter.sv
`timescale 1ns/1ps
module sim_dma_pair_arbiter;
    localparam int REST = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] req, prio, dst, term, susp;
    logic       done;
    logic [1:0] grant;
    logic       bus_cyc, cyc_deposit, rest_active;

    always #5 clk = ~clk;

    dma_pair_arbiter #(.REST_CYCLES(REST)) u0 (
        .clk (clk), .rst_n (rst_n), .ch_req (req), .ch_prio_hi (prio),
        .ch_dst_sync (dst), .ch_term (term), .ch_susp (susp), .bus_done (done),
        .grant (grant), .bus_cyc (bus_cyc), .cyc_deposit (cyc_deposit),
        .rest_active (rest_active)
    );

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    // Reference model: 0 idle, 1 fetch, 2 deposit, 3 idle window.
    int   m_st;
    logic m_own, m_last;
    int   m_cnt;

    // Returns {any, winner} following R2, R3, R4 and R7.
    function automatic logic [1:0] ref_pick(logic [1:0] el, logic [1:0] pr,
                                            logic lst, logic dem_en, logic dem);
        if (el == 2'b00) return 2'b00;
        if (el != 2'b11) return {1'b1, el[1]};
        if (dem_en) return {1'b1, ~dem};
        if (pr[0] != pr[1]) return {1'b1, pr[1]};
        return {1'b1, ~lst};
    endfunction

    task automatic model_step();
        logic [1:0] el;
        logic [1:0] pk;
        el = req & ~term & ~susp;
        if (!rst_n) begin
            m_st = 0; m_own = 1'b0; m_last = 1'b1; m_cnt = 0;
        end else begin
            case (m_st)
                0: begin
                    pk = ref_pick(el, prio, m_last, 1'b0, 1'b0);
                    if (pk[1]) begin m_st = 1; m_own = pk[0]; end
                end
                1: if (done) m_st = 2;
                2: if (done) begin
                    m_last = m_own;
                    if (dst[m_own]) begin
                        m_st = 3; m_cnt = 0;
                    end else begin
                        pk = ref_pick(el, prio, m_own, 1'b0, 1'b0);
                        if (pk[1]) begin m_st = 1; m_own = pk[0]; end
                        else m_st = 0;
                    end
                end
                default: begin
                    if (m_cnt == REST - 1) begin
                        pk = ref_pick(el, prio, m_last, 1'b1, m_own);
                        if (pk[1]) begin m_st = 1; m_own = pk[0]; end
                        else m_st = 0;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end
            endcase
        end
    endtask

    task automatic chk(string tag, string what, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: advance the model at the edge, compare at the falling edge.
    task automatic cyc();
        logic [1:0] eg;
        @(posedge clk);
        model_step();
        @(negedge clk);
        eg = (m_st == 1 || m_st == 2) ? (m_own ? 2'b10 : 2'b01) : 2'b00;
        chk("R2", "grant vs model", grant, eg);
        chk("R5", "bus_cyc vs model", {1'b0, bus_cyc}, {1'b0, (m_st == 1 || m_st == 2)});
        chk("R5", "deposit vs model", {1'b0, cyc_deposit}, {1'b0, m_st == 2});
        chk("R6", "rest vs model", {1'b0, rest_active}, {1'b0, m_st == 3});
        chk("R11", "onehot and bus match", {$onehot0(grant), bus_cyc == (grant != 2'b00)}, 2'b11);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = 0; prio = 0; dst = 0; term = 0; susp = 0; done = 0;
        cyc(); cyc();
        chk("R1", "grant in reset", grant, 2'b00);
        chk("R1", "bus/rest in reset", {bus_cyc | cyc_deposit, rest_active}, 2'b00);
        rst_n = 1'b1;
        cyc();
        chk("R1", "grant after reset", grant, 2'b00);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // R3 R6 R7 R8: high dst-sync ch1 interleaves with low src-sync ch0.
        do_reset();
        prio = 2'b10; dst = 2'b10; req = 2'b11; done = 1'b1;
        cyc(); chk("R3", "high channel first", grant, 2'b10);
        cyc(); chk("R5", "deposit phase", {1'b0, cyc_deposit}, 2'b01);
        cyc(); chk("R6", "window cycle 1", {rest_active, grant != 0}, 2'b10);
        cyc(); chk("R6", "window cycle 2", {rest_active, grant != 0}, 2'b10);
        cyc(); chk("R7", "low channel in window", grant, 2'b01);
        chk("R6", "window closed", {1'b0, rest_active}, 2'b00);
        cyc();
        cyc(); chk("R8", "high channel regains", grant, 2'b10);

        // R9: high src-sync ch0 chains transfers with no gap.
        do_reset();
        prio = 2'b01; dst = 2'b00; req = 2'b11; done = 1'b1;
        cyc(); chk("R3", "ch0 high wins", grant, 2'b01);
        cyc();
        cyc(); chk("R9", "back-to-back fetch", {grant[0], cyc_deposit}, 2'b10);

        // R4: equal priority rotates, ch0 first after reset.
        do_reset();
        prio = 2'b00; dst = 2'b00; req = 2'b11; done = 1'b1;
        cyc(); chk("R4", "ch0 first", grant, 2'b01);
        cyc();
        cyc(); chk("R4", "rotate to ch1", grant, 2'b10);
        cyc();
        cyc(); chk("R4", "rotate back to ch0", grant, 2'b01);

        // R10: stop inputs mid-transfer do not abort it.
        do_reset();
        req = 2'b01; done = 1'b0;
        cyc(); chk("R10", "granted", grant, 2'b01);
        term = 2'b01; susp = 2'b01; req = 2'b00;
        for (int k = 0; k < 3; k++) begin
            cyc(); chk("R10", "fetch held", {grant[0], cyc_deposit}, 2'b10);
        end
        done = 1'b1;
        cyc(); chk("R10", "deposit still done", {grant[0], cyc_deposit}, 2'b11);
        cyc(); chk("R2", "no eligible, no grant", grant, 2'b00);

        // R2: stop conditions block grants.
        do_reset();
        req = 2'b11; term = 2'b10; susp = 2'b01; done = 1'b0;
        cyc(); cyc(); chk("R2", "blocked", grant, 2'b00);
        susp = 2'b00;
        cyc(); chk("R2", "ch0 eligible", grant, 2'b01);

        // R7: lone dst-sync channel resumes after its window.
        do_reset();
        prio = 2'b00; dst = 2'b10; req = 2'b10; done = 1'b1;
        cyc(); chk("R2", "ch1 alone", grant, 2'b10);
        cyc(); cyc(); cyc();
        chk("R6", "second window cycle", {1'b0, rest_active}, 2'b01);
        cyc(); chk("R7", "resting channel resumes", grant, 2'b10);

        // Random phase against the model.
        do_reset();
        for (int k = 0; k < 5000; k++) begin
            if (k % 64 == 0) begin
                prio = 2'($urandom);
                dst  = 2'($urandom);
            end
            req  = 2'($urandom);
            term = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            susp = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            done = ($urandom % 3 != 0);
            cyc();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule